// File: doc/BRIEF.md
# Four-Class Dimension-Ordered Mesh Router

This block is a single switching node for a two-dimensional mesh network-on-chip. It has five ports: a local port toward the attached module and four mesh ports toward the north, south, east and west neighbours. Every flit carries one of four service classes. Each input port holds a separate small queue for each class, so an urgent flit never waits behind a bulk flit held in another queue. Packets travel as worms: a head flit claims an output for its class, and body and tail flits follow on that claim until the tail releases it.

Routing is fixed and shortest-path. A packet first travels along X until its column matches this node's column, then along Y, then leaves on the local port. The node learns its own position from two configuration inputs. Y grows toward the north and X grows toward the east. Each output forwards at most one flit per cycle and picks it by strict class priority. Classes share the link flit by flit, so a long bulk worm gets interrupted whenever a more urgent flit is ready. Flow control uses per-class credits in both directions. A mesh port can be removed at build time, and a removed port is never used.

Top module: `mesh_qos_router`

## Requirements
- R1: A flit has the layout {class[1:0], kind[1:0], payload[DATA_W-1:0]}. It is taken into the queue for its input and class on the edge where it is valid. With nothing in its way, it appears unchanged on its output exactly two cycles after the cycle it was driven.
- R2: Head and single flits carry the destination X in payload bits [COORD_W-1:0] and the destination Y in bits [2*COORD_W-1:COORD_W]. Port indices are 0 local, 1 north, 2 south, 3 east, 4 west. The output is chosen in this order: east if destination X > own X, west if destination X < own X, otherwise north if destination Y > own Y, south if destination Y < own Y, otherwise local.
- R3: The kind codes are 0 head, 1 body, 2 tail, 3 single. A granted head reserves its output for its class and input until its tail is granted. While the reservation holds, heads of the same class from other inputs wait.
- R4: Whenever several classes are ready on one output in the same cycle, class 0 goes first, then 1, then 2, then 3.
- R5: A worm of a lower class that is in progress on an output is interleaved flit by flit with a higher-class flit that arrives during the worm.
- R6: On each output, heads of one class from different inputs are served round-robin. After reset, the search starts at input 0. After each grant it restarts at the input after the one just granted.
- R7: Each output keeps a credit count per class, set to DOWN_DEPTH by reset. A send lowers the count and an outCreditRet pulse raises it. A class whose count is zero is held back, and the other classes on that output keep flowing.
- R8: inCreditRet[p][c] pulses for one cycle, in the same cycle in which the flit that left queue (p,c) appears on its output.
- R9: An output whose bit in PORT_EN is 0 never asserts outValid. A flit routed to it is delivered on no port.
- R10: During reset and on the cycle after it, every outValid and every inCreditRet is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgX | input | COORD_W | This node's column |
| cfgY | input | COORD_W | This node's row |
| inValid | input | 5 | Flit valid, one bit per input port |
| inFlit | input | 5 x (DATA_W+4) | Incoming flit, one per input port |
| inCreditRet | output | 5 x 4 | Credit back to the upstream sender, per input port and class |
| outValid | output | 5 | Flit valid, one bit per output port |
| outFlit | output | 5 x (DATA_W+4) | Outgoing flit, one per output port |
| outCreditRet | input | 5 x 4 | Credit from the downstream receiver, per output port and class |

## Verification
A flit driven in cycle N is written into its queue at the next edge. It is granted in the same cycle, so it reaches the output register and outValid in cycle N+2. The upstream credit pulse for that flit appears in that same cycle N+2. A downstream credit pulsed in cycle M lets a held flit out in cycle M+2.

The bench drives inputs and samples outputs on the falling edge, and counts cycles on the rising edge. Each check compares the recorded cycle stamp, or the value seen at that sample, against the cycle worked out from these latencies. When several flits compete, the bench works out the full output order from the priority and round-robin rules, cycle by cycle, and compares it against a per-port log of what left the router.

// File: rtl/mesh_router_pkg.sv
package mesh_router_pkg;
  localparam int NP = 5;
  localparam int NC = 4;

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_NORTH = 3'd1,
    PORT_SOUTH = 3'd2,
    PORT_EAST  = 3'd3,
    PORT_WEST  = 3'd4
  } portE;

  typedef enum logic [1:0] {
    KIND_HEAD   = 2'd0,
    KIND_BODY   = 2'd1,
    KIND_TAIL   = 2'd2,
    KIND_SINGLE = 2'd3
  } kindE;

  // strobes from control to datapath for one cycle
  typedef struct packed {
    logic [NP-1:0][NC-1:0] pop;
    logic [NP-1:0]         send;
    logic [NP-1:0][2:0]    selIn;
    logic [NP-1:0][1:0]    selCls;
  } xbarStrobeT;
endpackage

// File: rtl/mesh_router_fifo.sv
module mesh_router_fifo #(
  parameter int WIDTH = 20,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             notEmpty
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             doPush, doPop;

  assign notEmpty = (count != '0);
  assign doPush   = push && (count != CNT_W'(DEPTH));
  assign doPop    = pop && notEmpty;
  assign dout     = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) begin
        mem[wrPtr] <= din;
        wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      end
      if (doPop) rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end
endmodule

// File: rtl/mesh_router_datapath.sv
module mesh_router_datapath
  import mesh_router_pkg::*;
#(
  parameter int          DATA_W     = 16,
  parameter int          COORD_W    = 3,
  parameter int          FIFO_DEPTH = 4,
  parameter logic [4:0]  PORT_EN    = 5'b11111
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [NP-1:0]                      inValid,
  input  logic [NP-1:0][DATA_W+3:0]          inFlit,
  input  xbarStrobeT                         strobe,
  output logic [NP-1:0][NC-1:0]              frontAvail,
  output logic [NP-1:0][NC-1:0][1:0]         frontKind,
  output logic [NP-1:0][NC-1:0][COORD_W-1:0] frontDx,
  output logic [NP-1:0][NC-1:0][COORD_W-1:0] frontDy,
  output logic [NP-1:0]                      outValid,
  output logic [NP-1:0][DATA_W+3:0]          outFlit
);
  localparam int FW = DATA_W + 4;

  logic [FW-1:0] front [NP][NC];
  logic [NP-1:0][FW-1:0] muxFlit;

  for (genvar i = 0; i < NP; i++) begin : g_in
    for (genvar c = 0; c < NC; c++) begin : g_cls
      logic pushQ;
      assign pushQ = PORT_EN[i] && inValid[i] && (inFlit[i][FW-1:FW-2] == 2'(c));
      mesh_router_fifo #(.WIDTH(FW), .DEPTH(FIFO_DEPTH)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .push     (pushQ),
        .pop      (strobe.pop[i][c]),
        .din      (inFlit[i]),
        .dout     (front[i][c]),
        .notEmpty (frontAvail[i][c])
      );
      assign frontKind[i][c] = front[i][c][FW-3:FW-4];
      assign frontDx[i][c]   = front[i][c][COORD_W-1:0];
      assign frontDy[i][c]   = front[i][c][2*COORD_W-1:COORD_W];
    end
  end

  always_comb begin
    for (int o = 0; o < NP; o++) begin
      muxFlit[o] = '0;
      for (int i = 0; i < NP; i++)
        for (int c = 0; c < NC; c++)
          if (strobe.selIn[o] == 3'(i) && strobe.selCls[o] == 2'(c))
            muxFlit[o] = front[i][c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= '0;
      outFlit  <= '0;
    end else begin
      outValid <= strobe.send & PORT_EN;
      outFlit  <= muxFlit;
    end
  end
endmodule

// File: rtl/mesh_router_control.sv
module mesh_router_control
  import mesh_router_pkg::*;
#(
  parameter int         COORD_W    = 3,
  parameter int         DOWN_DEPTH = 4,
  parameter logic [4:0] PORT_EN    = 5'b11111
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [COORD_W-1:0]                 cfgX,
  input  logic [COORD_W-1:0]                 cfgY,
  input  logic [NP-1:0][NC-1:0]              frontAvail,
  input  logic [NP-1:0][NC-1:0][1:0]         frontKind,
  input  logic [NP-1:0][NC-1:0][COORD_W-1:0] frontDx,
  input  logic [NP-1:0][NC-1:0][COORD_W-1:0] frontDy,
  input  logic [NP-1:0][NC-1:0]              outCreditRet,
  output xbarStrobeT                         strobe,
  output logic [NP-1:0][NC-1:0]              inCreditRet
);
  localparam int CRD_W = $clog2(DOWN_DEPTH + 1);

  // per output and class
  logic [NP-1:0][NC-1:0]            busy;
  logic [NP-1:0][NC-1:0][2:0]       owner;
  logic [NP-1:0][NC-1:0][2:0]       rrPtr;
  logic [NP-1:0][NC-1:0][CRD_W-1:0] credit;
  logic [NP-1:0][NC-1:0][NP-1:0]    req;
  logic [NP-1:0][NC-1:0]            hasReq;
  logic [NP-1:0][NC-1:0][2:0]       winIn;
  logic [NP-1:0][NC-1:0]            grant;
  logic [NP-1:0][NC-1:0][1:0]       grantKind;
  logic [NP-1:0]                    found;
  // per input and class
  logic [NP-1:0][NC-1:0][2:0]       wormRoute;
  logic [NP-1:0][NC-1:0][2:0]       target;
  logic [NP-1:0][NC-1:0]            isHead;

  function automatic logic [2:0] xyRoute(input logic [COORD_W-1:0] dx, input logic [COORD_W-1:0] dy,
                                         input logic [COORD_W-1:0] mx, input logic [COORD_W-1:0] my);
    if (dx > mx)      return PORT_EAST;
    else if (dx < mx) return PORT_WEST;
    else if (dy > my) return PORT_NORTH;
    else if (dy < my) return PORT_SOUTH;
    else              return PORT_LOCAL;
  endfunction

  always_comb begin
    for (int i = 0; i < NP; i++)
      for (int c = 0; c < NC; c++) begin
        isHead[i][c] = (frontKind[i][c] == KIND_HEAD) || (frontKind[i][c] == KIND_SINGLE);
        target[i][c] = isHead[i][c] ? xyRoute(frontDx[i][c], frontDy[i][c], cfgX, cfgY)
                                    : wormRoute[i][c];
      end
  end

  always_comb begin
    for (int o = 0; o < NP; o++)
      for (int c = 0; c < NC; c++)
        for (int i = 0; i < NP; i++)
          req[o][c][i] = PORT_EN[o] && frontAvail[i][c] && (target[i][c] == 3'(o))
                         && (credit[o][c] != '0)
                         && (isHead[i][c] ? !busy[o][c]
                                          : (busy[o][c] && owner[o][c] == 3'(i)));
  end

  // round-robin pick per output and class
  always_comb begin
    for (int o = 0; o < NP; o++)
      for (int c = 0; c < NC; c++) begin
        hasReq[o][c] = 1'b0;
        winIn[o][c]  = '0;
        for (int k = 1; k <= NP; k++)
          if (!hasReq[o][c] && req[o][c][(int'(rrPtr[o][c]) + k) % NP]) begin
            hasReq[o][c] = 1'b1;
            winIn[o][c]  = 3'((int'(rrPtr[o][c]) + k) % NP);
          end
      end
  end

  // strict class priority per output
  always_comb begin
    strobe    = '0;
    grant     = '0;
    grantKind = '0;
    found     = '0;
    for (int o = 0; o < NP; o++)
      for (int c = 0; c < NC; c++)
        if (!found[o] && hasReq[o][c]) begin
          found[o]         = 1'b1;
          grant[o][c]      = 1'b1;
          strobe.send[o]   = 1'b1;
          strobe.selCls[o] = 2'(c);
          strobe.selIn[o]  = winIn[o][c];
        end
    for (int o = 0; o < NP; o++)
      for (int c = 0; c < NC; c++)
        for (int i = 0; i < NP; i++)
          if (grant[o][c] && winIn[o][c] == 3'(i)) begin
            strobe.pop[i][c] = 1'b1;
            grantKind[o][c]  = frontKind[i][c];
          end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= '0;
      owner       <= '0;
      wormRoute   <= '0;
      inCreditRet <= '0;
      for (int o = 0; o < NP; o++)
        for (int c = 0; c < NC; c++) begin
          rrPtr[o][c]  <= 3'(NP - 1);
          credit[o][c] <= CRD_W'(DOWN_DEPTH);
        end
    end else begin
      inCreditRet <= strobe.pop;
      for (int o = 0; o < NP; o++)
        for (int c = 0; c < NC; c++) begin
          credit[o][c] <= credit[o][c] + CRD_W'(outCreditRet[o][c]) - CRD_W'(grant[o][c]);
          if (grant[o][c]) begin
            if (grantKind[o][c] == KIND_HEAD) begin
              busy[o][c]  <= 1'b1;
              owner[o][c] <= winIn[o][c];
            end
            if (grantKind[o][c] == KIND_TAIL) busy[o][c] <= 1'b0;
            if (grantKind[o][c] == KIND_HEAD || grantKind[o][c] == KIND_SINGLE)
              rrPtr[o][c] <= winIn[o][c];
          end
          for (int i = 0; i < NP; i++)
            if (grant[o][c] && winIn[o][c] == 3'(i) && grantKind[o][c] == KIND_HEAD)
              wormRoute[i][c] <= 3'(o);
        end
    end
  end
endmodule

// File: rtl/mesh_qos_router.sv
module mesh_qos_router
  import mesh_router_pkg::*;
#(
  parameter int         DATA_W     = 16,
  parameter int         COORD_W    = 3,
  parameter int         FIFO_DEPTH = 4,
  parameter int         DOWN_DEPTH = 4,
  parameter logic [4:0] PORT_EN    = 5'b11111
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [COORD_W-1:0]        cfgX,
  input  logic [COORD_W-1:0]        cfgY,
  input  logic [NP-1:0]             inValid,
  input  logic [NP-1:0][DATA_W+3:0] inFlit,
  output logic [NP-1:0][NC-1:0]     inCreditRet,
  output logic [NP-1:0]             outValid,
  output logic [NP-1:0][DATA_W+3:0] outFlit,
  input  logic [NP-1:0][NC-1:0]     outCreditRet
);
  xbarStrobeT                         strobe;
  logic [NP-1:0][NC-1:0]              frontAvail;
  logic [NP-1:0][NC-1:0][1:0]         frontKind;
  logic [NP-1:0][NC-1:0][COORD_W-1:0] frontDx;
  logic [NP-1:0][NC-1:0][COORD_W-1:0] frontDy;

  mesh_router_datapath #(
    .DATA_W(DATA_W), .COORD_W(COORD_W), .FIFO_DEPTH(FIFO_DEPTH), .PORT_EN(PORT_EN)
  ) u_dp (
    .clk(clk), .rst(rst), .inValid(inValid), .inFlit(inFlit), .strobe(strobe),
    .frontAvail(frontAvail), .frontKind(frontKind), .frontDx(frontDx), .frontDy(frontDy),
    .outValid(outValid), .outFlit(outFlit)
  );

  mesh_router_control #(
    .COORD_W(COORD_W), .DOWN_DEPTH(DOWN_DEPTH), .PORT_EN(PORT_EN)
  ) u_ctl (
    .clk(clk), .rst(rst), .cfgX(cfgX), .cfgY(cfgY),
    .frontAvail(frontAvail), .frontKind(frontKind), .frontDx(frontDx), .frontDy(frontDy),
    .outCreditRet(outCreditRet), .strobe(strobe), .inCreditRet(inCreditRet)
  );
endmodule

// File: rtl/mesh_router_checker.sv
module mesh_router_checker
  import mesh_router_pkg::*;
#(
  parameter int         DATA_W     = 16,
  parameter int         COORD_W    = 3,
  parameter int         DOWN_DEPTH = 4,
  parameter logic [4:0] PORT_EN    = 5'b11111
) (
  input logic                      clk,
  input logic                      rst,
  input logic [COORD_W-1:0]        cfgX,
  input logic [COORD_W-1:0]        cfgY,
  input logic [NP-1:0][NC-1:0]     inCreditRet,
  input logic [NP-1:0]             outValid,
  input logic [NP-1:0][DATA_W+3:0] outFlit,
  input logic [NP-1:0][NC-1:0]     outCreditRet
);
  localparam int FW    = DATA_W + 4;
  localparam int CNT_W = $clog2(DOWN_DEPTH + 1) + 1;

  logic [NP-1:0][NC-1:0]            wormOpen;
  logic [NP-1:0][NC-1:0][CNT_W-1:0] outstanding;
  logic unusedTag;
  assign unusedTag = ^outFlit;

  function automatic logic [2:0] expPort(input logic [COORD_W-1:0] dx, input logic [COORD_W-1:0] dy);
    if (dx > cfgX)      return 3'd3;
    else if (dx < cfgX) return 3'd4;
    else if (dy > cfgY) return 3'd1;
    else if (dy < cfgY) return 3'd2;
    else                return 3'd0;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wormOpen    <= '0;
      outstanding <= '0;
    end else begin
      for (int o = 0; o < NP; o++)
        for (int c = 0; c < NC; c++) begin
          if (outValid[o] && outFlit[o][FW-1:FW-2] == 2'(c)) begin
            if (outFlit[o][FW-3:FW-4] == KIND_HEAD) wormOpen[o][c] <= 1'b1;
            if (outFlit[o][FW-3:FW-4] == KIND_TAIL) wormOpen[o][c] <= 1'b0;
          end
          outstanding[o][c] <= outstanding[o][c]
                               + CNT_W'(outValid[o] && outFlit[o][FW-1:FW-2] == 2'(c))
                               - CNT_W'(outCreditRet[o][c]);
        end
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (outValid == '0 && inCreditRet == '0)); // R10

  for (genvar o = 0; o < NP; o++) begin : g_out
    if (!PORT_EN[o]) begin : g_absent
      AST_ABSENT_PORT_IDLE: assert property (@(posedge clk) disable iff (rst) !outValid[o]); // R9
    end
    AST_HEAD_ON_XY_PORT: assert property (@(posedge clk) disable iff (rst)
      (outValid[o] && (outFlit[o][FW-3:FW-4] == KIND_HEAD || outFlit[o][FW-3:FW-4] == KIND_SINGLE))
      |-> (expPort(outFlit[o][COORD_W-1:0], outFlit[o][2*COORD_W-1:COORD_W]) == 3'(o))); // R2
    for (genvar c = 0; c < NC; c++) begin : g_cls
      AST_WORM_CONTINUES: assert property (@(posedge clk) disable iff (rst)
        (outValid[o] && outFlit[o][FW-1:FW-2] == 2'(c)
         && (outFlit[o][FW-3:FW-4] == KIND_BODY || outFlit[o][FW-3:FW-4] == KIND_TAIL))
        |-> wormOpen[o][c]); // R3
      AST_WORM_NOT_NESTED: assert property (@(posedge clk) disable iff (rst)
        (outValid[o] && outFlit[o][FW-1:FW-2] == 2'(c)
         && (outFlit[o][FW-3:FW-4] == KIND_HEAD || outFlit[o][FW-3:FW-4] == KIND_SINGLE))
        |-> !wormOpen[o][c]); // R3
      AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (rst)
        outstanding[o][c] <= CNT_W'(DOWN_DEPTH)); // R7
    end
  end
endmodule

bind mesh_qos_router mesh_router_checker #(
  .DATA_W(DATA_W), .COORD_W(COORD_W), .DOWN_DEPTH(DOWN_DEPTH), .PORT_EN(PORT_EN)
) u_chk (
  .clk(clk), .rst(rst), .cfgX(cfgX), .cfgY(cfgY), .inCreditRet(inCreditRet),
  .outValid(outValid), .outFlit(outFlit), .outCreditRet(outCreditRet)
);

// File: tb/mesh_qos_router_test.sv
`timescale 1ns/1ps
module mesh_qos_router_test;
  localparam int DATA_W = 16;
  localparam int CW     = 3;
  localparam int FW     = DATA_W + 4;
  localparam int NP     = 5;
  localparam int NC     = 4;
  localparam logic [4:0] PEN = 5'b11011; // south port absent

  localparam logic [1:0] HEAD = 2'd0, BODY = 2'd1, TAIL = 2'd2, SINGLE = 2'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] cfgX = 3'd2, cfgY = 3'd2;
  logic [NP-1:0] inValid = '0;
  logic [NP-1:0][FW-1:0] inFlit = '0;
  logic [NP-1:0][NC-1:0] inCreditRet;
  logic [NP-1:0] outValid;
  logic [NP-1:0][FW-1:0] outFlit;
  logic [NP-1:0][NC-1:0] autoCr = '0, manualCr = '0;
  logic [NC-1:0] autoEn = '1;

  int cyc = 0;
  int nChecks = 0, nFail = 0;
  logic [FW-1:0] logF [NP][256];
  int logC [NP][256];
  int logN [NP];

  mesh_qos_router #(.DATA_W(DATA_W), .COORD_W(CW), .FIFO_DEPTH(4), .DOWN_DEPTH(4), .PORT_EN(PEN)) uut (
    .clk(clk), .rst(rst), .cfgX(cfgX), .cfgY(cfgY), .inValid(inValid), .inFlit(inFlit),
    .inCreditRet(inCreditRet), .outValid(outValid), .outFlit(outFlit),
    .outCreditRet(autoCr | manualCr)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial for (int p = 0; p < NP; p++) logN[p] = 0;

  always @(negedge clk) begin
    for (int o = 0; o < NP; o++) begin
      for (int c = 0; c < NC; c++)
        autoCr[o][c] <= autoEn[c] && outValid[o] && (outFlit[o][FW-1:FW-2] == 2'(c));
      if (outValid[o] && logN[o] < 256) begin
        logF[o][logN[o]] = outFlit[o];
        logC[o][logN[o]] = cyc;
        logN[o] = logN[o] + 1;
      end
    end
  end

  function automatic logic [FW-1:0] mk(input logic [1:0] cls, input logic [1:0] kind,
                                       input logic [CW-1:0] dx, input logic [CW-1:0] dy,
                                       input logic [9:0] tag);
    return {cls, kind, tag, dy, dx};
  endfunction

  function automatic logic [9:0] tagOf(input logic [FW-1:0] f);
    return f[DATA_W-1:2*CW];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    chk(outValid == '0, "R10 outValid in reset", 32'(outValid), 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(outValid == '0, "R10 outValid after reset", 32'(outValid), 0);
    chk(inCreditRet == '0, "R10 inCreditRet after reset", 32'(inCreditRet), 0);
  endtask

  task automatic testLocalLatency();
    logic [FW-1:0] f;
    f = mk(2'd2, SINGLE, 3'd2, 3'd2, 10'h011);
    @(negedge clk); inValid[1] = 1'b1; inFlit[1] = f;
    @(negedge clk); inValid = '0;
    chk(outValid == '0, "R1 no output one cycle after drive", 32'(outValid), 0);
    @(negedge clk);
    chk(outValid == 5'b00001, "R1 local delivery at +2", 32'(outValid), 1);
    chk(outFlit[0] == f, "R1 flit unchanged", 32'(outFlit[0]), 32'(f));
    chk(inCreditRet[1][2] == 1'b1, "R8 upstream credit with output", 32'(inCreditRet), 32'h1 << 6);
    @(negedge clk);
    chk(inCreditRet == '0, "R8 credit pulse one cycle", 32'(inCreditRet), 0);
  endtask

  task automatic routeCase(input logic [CW-1:0] dx, input logic [CW-1:0] dy, input int expPort,
                           input logic [9:0] tag);
    logic [FW-1:0] f;
    f = mk(2'd1, SINGLE, dx, dy, tag);
    @(negedge clk); inValid[0] = 1'b1; inFlit[0] = f;
    @(negedge clk); inValid = '0;
    @(negedge clk);
    chk(outValid == (5'b1 << expPort), "R2 xy output port", 32'(outValid), 32'h1 << expPort);
    chk(outFlit[expPort] == f, "R2 routed flit", 32'(outFlit[expPort]), 32'(f));
    idle(2);
  endtask

  task automatic testWormhole();
    int base, n0;
    logic [9:0] expTag [4];
    expTag = '{10'h031, 10'h032, 10'h033, 10'h034};
    base = logN[3];
    @(negedge clk); n0 = cyc;
    inValid[1] = 1'b1; inFlit[1] = mk(2'd2, HEAD, 3'd4, 3'd2, 10'h031);
    inValid[4] = 1'b1; inFlit[4] = mk(2'd2, SINGLE, 3'd4, 3'd2, 10'h034);
    @(negedge clk); inValid = '0; inValid[1] = 1'b1; inFlit[1] = mk(2'd2, BODY, 3'd0, 3'd0, 10'h032);
    @(negedge clk); inFlit[1] = mk(2'd2, TAIL, 3'd0, 3'd0, 10'h033);
    @(negedge clk); inValid = '0;
    idle(6);
    chk(logN[3] - base == 4, "R3 flit count on east", 32'(logN[3] - base), 4);
    for (int k = 0; k < 4; k++)
      chk(tagOf(logF[3][base + k]) == expTag[k], "R3 worm order then waiting head",
          32'(tagOf(logF[3][base + k])), 32'(expTag[k]));
    chk(logC[3][base + 3] == n0 + 5, "R3 waiting head released after tail", 32'(logC[3][base + 3]), 32'(n0 + 5));
  endtask

  task automatic testPriority();
    int base, n0;
    base = logN[3];
    @(negedge clk); n0 = cyc;
    inValid[0] = 1'b1; inFlit[0] = mk(2'd3, SINGLE, 3'd5, 3'd2, 10'h043);
    inValid[4] = 1'b1; inFlit[4] = mk(2'd0, SINGLE, 3'd5, 3'd2, 10'h040);
    inValid[1] = 1'b1; inFlit[1] = mk(2'd1, SINGLE, 3'd5, 3'd2, 10'h041);
    @(negedge clk); inValid = '0;
    idle(5);
    for (int k = 0; k < 3; k++) begin
      logic [1:0] ec;
      ec = (k == 2) ? 2'd3 : 2'(k);
      chk(logF[3][base + k][FW-1:FW-2] == ec && logC[3][base + k] == n0 + 2 + k,
          "R4 class order on shared output", 32'(logF[3][base + k][FW-1:FW-2]), 32'(ec));
    end
  endtask

  task automatic testPreempt();
    int base, n0;
    base = logN[3];
    @(negedge clk); n0 = cyc; inValid[0] = 1'b1; inFlit[0] = mk(2'd3, HEAD, 3'd6, 3'd2, 10'h050);
    @(negedge clk); inFlit[0] = mk(2'd3, BODY, 3'd0, 3'd0, 10'h051);
    @(negedge clk); inFlit[0] = mk(2'd3, BODY, 3'd0, 3'd0, 10'h052);
    inValid[1] = 1'b1; inFlit[1] = mk(2'd0, SINGLE, 3'd6, 3'd2, 10'h05f);
    @(negedge clk); inValid = '0; inValid[0] = 1'b1; inFlit[0] = mk(2'd3, TAIL, 3'd0, 3'd0, 10'h053);
    @(negedge clk); inValid = '0;
    idle(6);
    chk(logN[3] - base == 5, "R5 five flits on east", 32'(logN[3] - base), 5);
    chk(tagOf(logF[3][base + 2]) == 10'h05f, "R5 urgent flit inside worm", 32'(tagOf(logF[3][base + 2])), 32'h05f);
    chk(logC[3][base + 2] == n0 + 4, "R5 urgent flit cycle", 32'(logC[3][base + 2]), 32'(n0 + 4));
    chk(tagOf(logF[3][base + 4]) == 10'h053, "R5 worm tail last", 32'(tagOf(logF[3][base + 4])), 32'h053);
  endtask

  task automatic testRoundRobin();
    int base, n0;
    logic [9:0] expTag [4];
    expTag = '{10'h061, 10'h063, 10'h062, 10'h064};
    base = logN[4];
    @(negedge clk); n0 = cyc;
    inValid[1] = 1'b1; inFlit[1] = mk(2'd2, SINGLE, 3'd0, 3'd2, 10'h061);
    inValid[3] = 1'b1; inFlit[3] = mk(2'd2, SINGLE, 3'd0, 3'd2, 10'h063);
    @(negedge clk);
    inFlit[1] = mk(2'd2, SINGLE, 3'd0, 3'd2, 10'h062);
    inFlit[3] = mk(2'd2, SINGLE, 3'd0, 3'd2, 10'h064);
    @(negedge clk); inValid = '0;
    idle(6);
    for (int k = 0; k < 4; k++)
      chk(tagOf(logF[4][base + k]) == expTag[k] && logC[4][base + k] == n0 + 2 + k,
          "R6 alternating inputs on west", 32'(tagOf(logF[4][base + k])), 32'(expTag[k]));
  endtask

  task automatic testCredits();
    int base, n0, cnt3, m;
    bit sawCls1;
    autoEn[3] = 1'b0;
    base = logN[3];
    @(negedge clk); n0 = cyc;
    inValid[0] = 1'b1; inFlit[0] = mk(2'd3, SINGLE, 3'd7, 3'd2, 10'h070);
    inValid[4] = 1'b1; inFlit[4] = mk(2'd3, SINGLE, 3'd7, 3'd2, 10'h074);
    for (int k = 1; k < 4; k++) begin
      @(negedge clk); inValid = '0; inValid[0] = 1'b1; inFlit[0] = mk(2'd3, SINGLE, 3'd7, 3'd2, 10'(10'h070 + k));
    end
    @(negedge clk); inValid = '0; inValid[1] = 1'b1; inFlit[1] = mk(2'd1, SINGLE, 3'd7, 3'd2, 10'h07f);
    @(negedge clk); inValid = '0;
    idle(10);
    cnt3 = 0; sawCls1 = 1'b0;
    for (int k = base; k < logN[3]; k++) begin
      if (logF[3][k][FW-1:FW-2] == 2'd3) cnt3++;
      if (tagOf(logF[3][k]) == 10'h07f && logC[3][k] == n0 + 6) sawCls1 = 1'b1;
    end
    chk(cnt3 == 4, "R7 class held at zero credit after reset depth", 32'(cnt3), 4);
    chk(sawCls1, "R7 other class not stalled", 32'(sawCls1), 1);
    @(negedge clk); m = cyc; manualCr[3][3] = 1'b1;
    @(negedge clk); manualCr = '0;
    chk(outValid[3] == 1'b0, "R7 no send before credit takes effect", 32'(outValid[3]), 0);
    @(negedge clk);
    chk(outValid[3] && outFlit[3][FW-1:FW-2] == 2'd3 && cyc == m + 2, "R7 held flit sent after credit",
        32'(outValid[3]), 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); manualCr[3][3] = 1'b1;
      @(negedge clk); manualCr = '0;
    end
    autoEn = '1;
    idle(2);
  endtask

  task automatic testAbsentPort();
    int total0, total1;
    total0 = logN[0] + logN[1] + logN[2] + logN[3] + logN[4];
    @(negedge clk); inValid[3] = 1'b1; inFlit[3] = mk(2'd1, SINGLE, 3'd2, 3'd0, 10'h080);
    @(negedge clk); inValid = '0;
    idle(15);
    total1 = logN[0] + logN[1] + logN[2] + logN[3] + logN[4];
    chk(total1 == total0, "R9 flit to absent port delivered nowhere", 32'(total1 - total0), 0);
    chk(logN[2] == 0, "R9 absent port never valid", 32'(logN[2]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    idle(2);
    testLocalLatency();
    routeCase(3'd4, 3'd0, 3, 10'h021);
    routeCase(3'd0, 3'd4, 4, 10'h022);
    routeCase(3'd2, 3'd5, 1, 10'h023);
    routeCase(3'd2, 3'd2, 0, 10'h024);
    testWormhole();
    testPriority();
    testPreempt();
    testRoundRobin();
    testCredits();
    testAbsentPort();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule